// File: doc/BRIEF.md
# Rotating Write-Once Register File

This block holds the register state for a renaming scheme in which every register name is written exactly once. Storage is split into four partitions. Each one shows sixteen logical names, numbered 0 to 15, over a circular pool of 32 physical registers. A partition keeps its own rotation base, and a logical name maps to physical slot `(name + base) mod 32`. A read or write carries its own base value, so a requester can resolve names against the base it captured earlier rather than the current one.

An allocate command gives each partition a count K from 0 to 16. For every partition with K > 0, the command opens K fresh names at the top (names 16-K to 15) and moves every older value K names lower. The value that was at name 15 is then at name 15-K. The lowest K old names can no longer be reached with the new base. Fresh names start not-ready. A read reports ready only once the name has been written, and the consumer stalls on a not-ready result.

An allocation reuses physical slots, and those slots must first be released through the free strobe. The allocate interface follows valid/ready rules:

- `alloc_ready` is computed in the same cycle from the counts on `alloc_cnt` and the current state.
- The command is taken at the clock edge where `alloc_valid` and `alloc_ready` are both high.
- While `alloc_ready` is low, the requester keeps `alloc_valid` high and holds `alloc_cnt` unchanged.

The physical pool size must be a power of two and at least twice the logical name count.

Top module: `rwo_regfile`

## Requirements
- R1: After reset, every rotation base on `base_o` is 0. Logical names 0..15 of every partition (base 0) are allocated and not ready, so a write to them is accepted.
- R2: A read or write of logical name n with supplied base b addresses physical slot (n + b) mod 32 of the chosen partition, whatever the partition's current base is.
- R3: A write to an allocated, not-ready slot raises no error. It stores the data and sets the ready bit, and from the next cycle reads of that slot return the data with `rd_rdy` high.
- R4: A write to a slot that is already ready, or to a slot that is not allocated, sets its `wr_err` bit in the same cycle and is discarded: the slot's data and ready state stay unchanged.
- R5: When both write ports target the same physical slot in one cycle, port 0 is handled normally and port 1 reports `wr_err[1]` and is discarded.
- R6: An accepted allocate with count K advances the base by K. Old name j+K is then read as name j with the new base, and names 16-K..15 are not ready until written.
- R7: One allocate command applies each partition's own count at the same edge. A partition with count 0 keeps its base.
- R8: `alloc_ready` is low if any count exceeds 16 or if any slot the command would open is still in use. A refused command changes no base.
- R9: A free strobe on (partition, name, base) releases that physical slot: it becomes not ready, and a later allocate may reuse it.
- R10: Reads are combinational: `rd_data` and `rd_rdy` follow the read address inputs in the same cycle.
- R11: A read of a slot that is not ready returns `rd_rdy` low and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate command offered |
| alloc_cnt | input | 20 | Per-partition count K, 5 bits each, partition p at bits [5p+4:5p] |
| alloc_ready | output | 1 | Allocate command can be taken this cycle |
| base_o | output | 20 | Current rotation base, 5 bits per partition |
| wr_en | input | 2 | Write enable per write port |
| wr_part | input | 4 | Partition per write port, 2 bits each |
| wr_name | input | 8 | Logical name per write port, 4 bits each |
| wr_base | input | 10 | Requester base per write port, 5 bits each |
| wr_data | input | 32 | Write data, 16 bits per port |
| wr_err | output | 2 | Write rejected, per port, same cycle |
| fr_en | input | 1 | Free strobe |
| fr_part | input | 2 | Partition to free in |
| fr_name | input | 4 | Logical name to free |
| fr_base | input | 5 | Base used to resolve the freed name |
| rd_part | input | 4 | Partition per read port, 2 bits each |
| rd_name | input | 8 | Logical name per read port, 4 bits each |
| rd_base | input | 10 | Requester base per read port, 5 bits each |
| rd_data | output | 32 | Read data, 16 bits per port, zero when not ready |
| rd_rdy | output | 2 | Read slot holds a written value |

## Verification
Read data, read ready, write errors and `alloc_ready` are combinational, so each is due in the same cycle its inputs are applied. Stored data, ready bits and `base_o` change at the clock edge and are due one cycle later. The bench applies inputs just after a rising edge and queues the values expected for that cycle. A monitor compares them at the following falling edge, so checks of state effects are always placed in the step after the edge that causes them. Refused and discarded operations are checked by reading back the affected slot or base in that later step.

// File: rtl/rwo_pkg.sv
package rwo_pkg;
  localparam int NPORT = 2;

  typedef enum logic {
    WR_TAKE = 1'b0,
    WR_DROP = 1'b1
  } wr_verdict_e;
endpackage

// File: rtl/rwo_range_chk.sv
module rwo_range_chk #(
  parameter int NLOG  = 16,
  parameter int NPHYS = 32,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NLOG) + 1
) (
  input  logic [PW-1:0]    base,
  input  logic [CW-1:0]    cnt,
  input  logic [NPHYS-1:0] in_use,
  output logic [NPHYS-1:0] in_rng,
  output logic             ok
);
  // slots that a count of cnt would open sit just above the live window
  for (genvar i = 0; i < NPHYS; i++) begin : g_slot
    logic [PW-1:0] off;
    assign off       = PW'(i) - base - PW'(NLOG);
    assign in_rng[i] = (32'(off) < 32'(cnt));
  end

  assign ok = (32'(cnt) <= NLOG) && !(|(in_rng & in_use));
endmodule

// File: rtl/rwo_part.sv
module rwo_part import rwo_pkg::*; #(
  parameter int DW    = 16,
  parameter int NLOG  = 16,
  parameter int NPHYS = 32,
  localparam int LW = $clog2(NLOG),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = LW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_go,
  input  logic [CW-1:0]             alloc_cnt,
  output logic                      range_ok,
  output logic [PW-1:0]             base_q,
  input  logic [NPORT-1:0]          wr_en,
  input  logic [NPORT-1:0][LW-1:0]  wr_name,
  input  logic [NPORT-1:0][PW-1:0]  wr_base,
  input  logic [NPORT-1:0][DW-1:0]  wr_data,
  output logic [NPORT-1:0]          wr_bad,
  input  logic                      fr_en,
  input  logic [LW-1:0]             fr_name,
  input  logic [PW-1:0]             fr_base,
  input  logic [NPORT-1:0][LW-1:0]  rd_name,
  input  logic [NPORT-1:0][PW-1:0]  rd_base,
  output logic [NPORT-1:0][DW-1:0]  rd_data,
  output logic [NPORT-1:0]          rd_rdy
);
  logic [DW-1:0]             mem_q [NPHYS];
  logic [NPHYS-1:0]          rdy_q, use_q, rdy_d, use_d, fresh;
  logic [NPORT-1:0][PW-1:0]  wph, rph;
  logic [PW-1:0]             fph, top_ph;
  wr_verdict_e               verdict [NPORT];

  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      wph[k] = PW'(wr_name[k]) + wr_base[k];
      rph[k] = PW'(rd_name[k]) + rd_base[k];
    end
    fph    = PW'(fr_name) + fr_base;
    top_ph = base_q + PW'(NLOG - 1);
  end

  // write-once rule, lower port has priority on a shared slot
  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      verdict[k] = (!use_q[wph[k]] || rdy_q[wph[k]]) ? WR_DROP : WR_TAKE;
      for (int m = 0; m < k; m++)
        if (wr_en[m] && wph[m] == wph[k]) verdict[k] = WR_DROP;
      wr_bad[k] = (verdict[k] == WR_DROP);
    end
  end

  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      rd_rdy[k]  = use_q[rph[k]] && rdy_q[rph[k]];
      rd_data[k] = rd_rdy[k] ? mem_q[rph[k]] : '0;
    end
  end

  rwo_range_chk #(.NLOG(NLOG), .NPHYS(NPHYS)) u_rng (
    .base   (base_q),
    .cnt    (alloc_cnt),
    .in_use (use_q),
    .in_rng (fresh),
    .ok     (range_ok)
  );

  always_comb begin
    use_d = use_q;
    rdy_d = rdy_q;
    for (int k = 0; k < NPORT; k++)
      if (wr_en[k] && verdict[k] == WR_TAKE) rdy_d[wph[k]] = 1'b1;
    if (fr_en) begin
      use_d[fph] = 1'b0;
      rdy_d[fph] = 1'b0;
    end
    if (alloc_go) begin
      use_d = use_d | fresh;
      rdy_d = rdy_d & ~fresh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      rdy_q  <= '0;
      for (int i = 0; i < NPHYS; i++) begin
        mem_q[i] <= '0;
        use_q[i] <= (i < NLOG);
      end
    end else begin
      rdy_q <= rdy_d;
      use_q <= use_d;
      if (alloc_go) base_q <= base_q + PW'(alloc_cnt);
      for (int k = 0; k < NPORT; k++)
        if (wr_en[k] && verdict[k] == WR_TAKE) mem_q[wph[k]] <= wr_data[k];
    end
  end

  p_wr_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && !wr_bad[0] && !(fr_en && fph == wph[0])) |=> rdy_q[$past(wph[0])]);

  p_bad_wr_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && wr_bad[0]) |=> (mem_q[$past(wph[0])] == $past(mem_q[wph[0]])));

  p_alloc_needs_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_go |-> range_ok);

  p_idle_base_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_go |=> $stable(base_q));

  p_fresh_top_notready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && alloc_cnt != '0) |=> !rdy_q[top_ph]);
endmodule

// File: rtl/rwo_regfile.sv
module rwo_regfile import rwo_pkg::*; #(
  parameter int DW    = 16,
  parameter int NPART = 4,
  parameter int NLOG  = 16,
  parameter int NPHYS = 32,
  localparam int LW = $clog2(NLOG),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = LW + 1,
  localparam int SW = $clog2(NPART)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  input  logic [NPART*CW-1:0]   alloc_cnt,
  output logic                  alloc_ready,
  output logic [NPART*PW-1:0]   base_o,
  input  logic [NPORT-1:0]      wr_en,
  input  logic [NPORT*SW-1:0]   wr_part,
  input  logic [NPORT*LW-1:0]   wr_name,
  input  logic [NPORT*PW-1:0]   wr_base,
  input  logic [NPORT*DW-1:0]   wr_data,
  output logic [NPORT-1:0]      wr_err,
  input  logic                  fr_en,
  input  logic [SW-1:0]         fr_part,
  input  logic [LW-1:0]         fr_name,
  input  logic [PW-1:0]         fr_base,
  input  logic [NPORT*SW-1:0]   rd_part,
  input  logic [NPORT*LW-1:0]   rd_name,
  input  logic [NPORT*PW-1:0]   rd_base,
  output logic [NPORT*DW-1:0]   rd_data,
  output logic [NPORT-1:0]      rd_rdy
);
  logic [NPART-1:0]             rng_ok;
  logic                         alloc_go;
  logic [NPORT-1:0][SW-1:0]     wp, rp;
  logic [NPORT-1:0][LW-1:0]     wn, rn;
  logic [NPORT-1:0][PW-1:0]     wb, rb;
  logic [NPORT-1:0][DW-1:0]     wd, rd_mux;
  logic [NPORT-1:0]             pwe   [NPART];
  logic [NPORT-1:0]             pbad  [NPART];
  logic [NPORT-1:0]             prdy  [NPART];
  logic [NPORT-1:0][DW-1:0]     pdat  [NPART];

  assign wp = wr_part;
  assign rp = rd_part;
  assign wn = wr_name;
  assign rn = rd_name;
  assign wb = wr_base;
  assign rb = rd_base;
  assign wd = wr_data;

  assign alloc_ready = &rng_ok;
  assign alloc_go    = alloc_valid && alloc_ready;

  for (genvar g = 0; g < NPART; g++) begin : g_part
    always_comb
      for (int k = 0; k < NPORT; k++) pwe[g][k] = wr_en[k] && (wp[k] == SW'(g));

    rwo_part #(.DW(DW), .NLOG(NLOG), .NPHYS(NPHYS)) u_part (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_go  (alloc_go),
      .alloc_cnt (alloc_cnt[g*CW +: CW]),
      .range_ok  (rng_ok[g]),
      .base_q    (base_o[g*PW +: PW]),
      .wr_en     (pwe[g]),
      .wr_name   (wn),
      .wr_base   (wb),
      .wr_data   (wd),
      .wr_bad    (pbad[g]),
      .fr_en     (fr_en && (fr_part == SW'(g))),
      .fr_name   (fr_name),
      .fr_base   (fr_base),
      .rd_name   (rn),
      .rd_base   (rb),
      .rd_data   (pdat[g]),
      .rd_rdy    (prdy[g])
    );
  end

  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      rd_mux[k] = pdat[rp[k]][k];
      rd_rdy[k] = prdy[rp[k]][k];
      wr_err[k] = wr_en[k] && pbad[wp[k]][k];
    end
  end
  assign rd_data = rd_mux;

  p_refused_keeps_bases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(base_o));
endmodule

// File: tb/rwo_regfile_tb_top.sv
module rwo_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA = 0, PB = 1, PC = 2, PD = 3;
  localparam int K_DATA = 0, K_RDY = 1, K_ERR = 2, K_ARDY = 3, K_BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid;
  logic [19:0] alloc_cnt;
  logic        alloc_ready;
  logic [19:0] base_o;
  logic [1:0]  wr_en;
  logic [3:0]  wr_part;
  logic [7:0]  wr_name;
  logic [9:0]  wr_base;
  logic [31:0] wr_data;
  logic [1:0]  wr_err;
  logic        fr_en;
  logic [1:0]  fr_part;
  logic [3:0]  fr_name;
  logic [4:0]  fr_base;
  logic [3:0]  rd_part;
  logic [7:0]  rd_name;
  logic [9:0]  rd_base;
  logic [31:0] rd_data;
  logic [1:0]  rd_rdy;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  rwo_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_cnt(alloc_cnt),
    .alloc_ready(alloc_ready), .base_o(base_o), .wr_en(wr_en), .wr_part(wr_part),
    .wr_name(wr_name), .wr_base(wr_base), .wr_data(wr_data), .wr_err(wr_err),
    .fr_en(fr_en), .fr_part(fr_part), .fr_name(fr_name), .fr_base(fr_base),
    .rd_part(rd_part), .rd_name(rd_name), .rd_base(rd_base), .rd_data(rd_data),
    .rd_rdy(rd_rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sample(int kind, int idx);
    case (kind)
      K_DATA:  return 32'(rd_data[idx*16 +: 16]);
      K_RDY:   return 32'(rd_rdy[idx]);
      K_ERR:   return 32'(wr_err);
      K_ARDY:  return 32'(alloc_ready);
      default: return 32'(base_o[idx*5 +: 5]);
    endcase
  endfunction

  // monitor: compares everything queued for this cycle at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e   = q.pop_front();
      act = sample(e.kind, e.idx);
      n_chk++;
      if (act !== e.exp) begin
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h", e.tag, act, e.exp);
      end
    end
  end

  task automatic expect_v(int kind, int idx, logic [31:0] v, string tag);
    exp_t e;
    e.kind = kind; e.idx = idx; e.exp = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    wr_en = '0; fr_en = 1'b0;
  endtask

  task automatic rd(int p, int part, int name, int base);
    rd_part[p*2 +: 2] = 2'(part);
    rd_name[p*4 +: 4] = 4'(name);
    rd_base[p*5 +: 5] = 5'(base);
  endtask

  task automatic wr(int p, int part, int name, int base, int data);
    wr_en[p]           = 1'b1;
    wr_part[p*2 +: 2]  = 2'(part);
    wr_name[p*4 +: 4]  = 4'(name);
    wr_base[p*5 +: 5]  = 5'(base);
    wr_data[p*16 +: 16] = 16'(data);
  endtask

  task automatic set_cnt(int part, int k);
    alloc_cnt[part*5 +: 5] = 5'(k);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    alloc_valid = 1'b0; alloc_cnt = '0; wr_en = '0; wr_part = '0; wr_name = '0;
    wr_base = '0; wr_data = '0; fr_en = 1'b0; fr_part = '0; fr_name = '0;
    fr_base = '0; rd_part = '0; rd_name = '0; rd_base = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // S1 reset state
    for (int p = 0; p < 4; p++) expect_v(K_BASE, p, 0, "R1 base after reset");
    rd(0, PA, 0, 0); rd(1, PD, 15, 0);
    expect_v(K_RDY, 0, 0, "R1 name0 not ready");
    expect_v(K_DATA, 0, 0, "R11 not-ready data zero");
    expect_v(K_RDY, 1, 0, "R1 name15 not ready");
    expect_v(K_ARDY, 0, 1, "R7 zero counts allowed");

    // S2 first writes
    step();
    wr(0, PA, 0, 0, 16'h1111); wr(1, PA, 15, 0, 16'h2222);
    expect_v(K_ERR, 0, 0, "R1 R3 writes to reset names accepted");
    expect_v(K_RDY, 0, 0, "R3 not visible before edge");

    // S3
    step();
    rd(0, PA, 0, 0); rd(1, PA, 15, 0);
    expect_v(K_DATA, 0, 16'h1111, "R3 read data port0");
    expect_v(K_RDY, 0, 1, "R10 same-cycle read ready");
    expect_v(K_DATA, 1, 16'h2222, "R3 read data port1");
    wr(0, PA, 0, 0, 16'hdead); wr(1, PB, 5, 0, 16'h3333);
    expect_v(K_ERR, 0, 1, "R4 rewrite of ready name");

    // S4
    step();
    rd(0, PA, 0, 0); rd(1, PB, 5, 0);
    expect_v(K_DATA, 0, 16'h1111, "R4 rejected write left data");
    expect_v(K_DATA, 1, 16'h3333, "R3 partition B write");
    wr(0, PC, 2, 0, 16'h4444); wr(1, PC, 2, 0, 16'h5555);
    expect_v(K_ERR, 0, 2, "R5 port1 loses same slot");

    // S5
    step();
    rd(0, PC, 2, 0);
    expect_v(K_DATA, 0, 16'h4444, "R5 port0 value stored");
    wr(0, PA, 0, 16, 16'h6666);
    expect_v(K_ERR, 0, 1, "R4 write to unallocated slot");
    alloc_valid = 1'b1; set_cnt(PA, 2); set_cnt(PC, 3);
    expect_v(K_ARDY, 0, 1, "R7 multi-partition allocate ready");

    // S6
    step();
    alloc_valid = 1'b0; alloc_cnt = '0;
    expect_v(K_BASE, PA, 2, "R6 base A advanced");
    expect_v(K_BASE, PB, 0, "R7 zero count keeps base");
    expect_v(K_BASE, PC, 3, "R7 base C advanced");
    expect_v(K_BASE, PD, 0, "R7 base D unchanged");
    rd(0, PA, 13, 2); rd(1, PA, 15, 2);
    expect_v(K_DATA, 0, 16'h2222, "R6 old name15 now name13");
    expect_v(K_RDY, 1, 0, "R6 fresh name not ready");
    expect_v(K_DATA, 1, 0, "R11 fresh name data zero");

    // S7
    step();
    rd(0, PA, 14, 2); rd(1, PC, 2, 0);
    expect_v(K_RDY, 0, 0, "R4 rejected write left slot empty");
    expect_v(K_DATA, 1, 16'h4444, "R2 old base still resolves");
    wr(0, PA, 15, 2, 16'h7777);
    expect_v(K_ERR, 0, 0, "R6 fresh name writable");

    // S8
    step();
    rd(0, PA, 15, 2); rd(1, PC, 15, 3);
    expect_v(K_DATA, 0, 16'h7777, "R3 fresh name written");
    expect_v(K_RDY, 1, 0, "R6 fresh C name not ready");
    alloc_valid = 1'b1; set_cnt(PA, 15);
    expect_v(K_ARDY, 0, 0, "R8 reuse of busy slot refused");

    // S9
    step();
    expect_v(K_BASE, PA, 2, "R8 refused keeps base");
    fr_en = 1'b1; fr_part = 2'(PA); fr_name = 0; fr_base = 0;
    expect_v(K_ARDY, 0, 0, "R8 still busy before free edge");

    // S10
    step();
    rd(0, PA, 0, 0);
    expect_v(K_RDY, 0, 0, "R9 freed slot not ready");
    expect_v(K_ARDY, 0, 1, "R9 freed slot reusable");

    // S11
    step();
    alloc_valid = 1'b0; alloc_cnt = '0;
    expect_v(K_BASE, PA, 17, "R6 base wraps forward by 15");
    rd(0, PA, 0, 0); rd(1, PA, 0, 17);
    expect_v(K_RDY, 0, 0, "R9 reused slot fresh");
    expect_v(K_DATA, 1, 16'h7777, "R2 R6 shift by 15");

    // S12
    step();
    alloc_valid = 1'b1; set_cnt(PB, 1); set_cnt(PD, 17);
    expect_v(K_ARDY, 0, 0, "R8 count above 16 refused");

    // S13
    step();
    alloc_valid = 1'b0; alloc_cnt = '0;
    expect_v(K_BASE, PB, 0, "R8 refused command leaves B");
    expect_v(K_BASE, PD, 0, "R8 refused command leaves D");

    step();
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule